// File: doc/BRIEF.md
# Circular-Window Indirect Gather Address Generator

This block produces the address stream for an indirect gather. After a start command it walks a programmed number of elements. For each element it reads an index from an index memory and turns that index into a table row address. It then presents that address as a row request and waits for the request to be accepted before moving to the next element. The data movement behind the request, and the register storage that holds the window state, sit outside the block.

A one-bit source select chooses where each index is read. In scalar mode the index is read from a flat array that starts at a scalar base address, and the address advances by one for every element. In window mode the index is read through a circular window given by a base, a size and a live offset. The command does not name which window to use: the block takes the window state that was presented on its window inputs when the command was issued. After each accepted request the offset moves forward by one and wraps back to zero at the window size. When the stream ends, the final offset is returned so that the register holding it can be updated.

Top module: `cwin_gather_agen`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `idx_rd_en`, `req_valid`, `done` and `wb_valid` are all low.
- R2: A `start` pulse is taken only while `busy` is low. A `start` pulse raised while a stream is running has no effect: it adds no requests, adds no `done` pulse and does not change the addresses of the running stream.
- R3: With `src_sel` = 0, element k (counting from 0) reads its index at `scalar_base` + k, with no wrap.
- R4: With `src_sel` = 1, element k reads its index at `win_base` + ((`win_offset` + k) mod `win_size`). The offset advances by one after each accepted request and wraps to 0 when it reaches the size.
- R5: A starting `win_offset` that is equal to or larger than `win_size` is first reduced modulo `win_size`, before the first index is read.
- R6: The row address is `table_base` + index × `row_stride`, with the index read as an unsigned number and the result truncated to the address width.
- R7: Exactly one row request is issued per element, in element order. `req_valid` stays high with `req_addr` unchanged until `req_ready` is sampled high.
- R8: `done` is a single-cycle pulse. It is high in the cycle after the last accepted request. With a count of 0 in scalar mode, it is high in the cycle after `start` is sampled and no request is issued.
- R9: In window mode, `wb_valid` is high in the same cycle as `done`, and `wb_offset` then carries (`win_offset` + count) mod `win_size`. This also holds for a count of 0. In scalar mode `wb_valid` never goes high.
- R10: A `win_size` of 0 is treated as a window of one entry: every index is read at `win_base`, and the returned offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command pulse; taken only while idle |
| src_sel | input | 1 | Index source: 0 = scalar array, 1 = circular window |
| elem_count | input | CW | Number of elements in the stream |
| scalar_base | input | AW | Index array start address for scalar mode |
| table_base | input | AW | Row table start address |
| row_stride | input | AW | Distance in bytes between table rows |
| win_base | input | AW | Window start address |
| win_size | input | OW | Window length in entries |
| win_offset | input | OW | Window live offset when the command is issued |
| busy | output | 1 | High from command acceptance until the `done` cycle, inclusive |
| idx_rd_en | output | 1 | Index memory read strobe; data is expected one cycle later |
| idx_rd_addr | output | AW | Index memory read address |
| idx_rd_data | input | IW | Index memory read data |
| req_valid | output | 1 | Row request valid |
| req_ready | input | 1 | Row request accepted |
| req_addr | output | AW | Row request address |
| done | output | 1 | Stream completion pulse |
| wb_valid | output | 1 | Final window offset write-back strobe |
| wb_offset | output | OW | Final window offset |

## Verification
The hardest situation to reach is a window stream whose offset wraps several times while `req_ready` is stalling, combined with a starting offset that is above the size and must be reduced before the first read. The stimulus reaches it by programming a small window with an oversized offset and a count larger than the size, while an LFSR holds back `req_ready`. The scoreboard then shows any slip in wrap position, reduction or request holding as a wrong row address. A second command issued while that stream is running, with different parameters, covers the requirement that a start pulse during a stream has no effect.

// File: rtl/cwin_gather_agen.sv
module cwin_gather_agen #(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int CW = 16,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          src_sel,
  input  logic [CW-1:0] elem_count,
  input  logic [AW-1:0] scalar_base,
  input  logic [AW-1:0] table_base,
  input  logic [AW-1:0] row_stride,
  input  logic [AW-1:0] win_base,
  input  logic [OW-1:0] win_size,
  input  logic [OW-1:0] win_offset,
  output logic          busy,
  output logic          idx_rd_en,
  output logic [AW-1:0] idx_rd_addr,
  input  logic [IW-1:0] idx_rd_data,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic          done,
  output logic          wb_valid,
  output logic [OW-1:0] wb_offset
);

  typedef enum logic [2:0] {S_IDLE, S_NORM, S_FETCH, S_CALC, S_REQ, S_FIN} state_t;

  state_t        state;
  logic          src_q;
  logic [CW-1:0] cnt_q, elem_q;
  logic [AW-1:0] sbase_q, tbase_q, stride_q, win_base_q, raddr_q;
  logic [OW-1:0] size_q, off_q;
  logic [OW-1:0] off_inc;

  assign off_inc     = off_q + 1'b1;
  assign busy        = (state != S_IDLE);
  assign idx_rd_en   = (state == S_FETCH);
  assign idx_rd_addr = src_q ? win_base_q + AW'(off_q) : sbase_q + AW'(elem_q);
  assign req_valid   = (state == S_REQ);
  assign req_addr    = raddr_q;
  assign done        = (state == S_FIN);
  assign wb_valid    = done & src_q;
  assign wb_offset   = off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      src_q      <= 1'b0;
      cnt_q      <= '0;
      elem_q     <= '0;
      sbase_q    <= '0;
      tbase_q    <= '0;
      stride_q   <= '0;
      win_base_q <= '0;
      raddr_q    <= '0;
      size_q     <= '0;
      off_q      <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          src_q      <= src_sel;
          cnt_q      <= elem_count;
          elem_q     <= '0;
          sbase_q    <= scalar_base;
          tbase_q    <= table_base;
          stride_q   <= row_stride;
          win_base_q <= win_base;
          size_q     <= (win_size == '0) ? OW'(1) : win_size;
          off_q      <= win_offset;
          if (src_sel)                 state <= S_NORM;
          else if (elem_count == '0)   state <= S_FIN;
          else                         state <= S_FETCH;
        end
        S_NORM: begin
          if (off_q >= size_q)   off_q <= off_q - size_q;
          else if (cnt_q == '0)  state <= S_FIN;
          else                   state <= S_FETCH;
        end
        S_FETCH: state <= S_CALC;
        S_CALC: begin
          raddr_q <= tbase_q + AW'(idx_rd_data) * stride_q;
          state   <= S_REQ;
        end
        S_REQ: if (req_ready) begin
          elem_q <= elem_q + 1'b1;
          if (src_q) off_q <= (off_inc == size_q) ? '0 : off_inc;
          state <= (elem_q == cnt_q - 1'b1) ? S_FIN : S_FETCH;
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cwin_gather_agen_chk.sv
module cwin_gather_agen_chk #(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          idx_rd_en,
  input logic [AW-1:0] idx_rd_addr,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          done,
  input logic          wb_valid,
  input logic          src_q,
  input logic [AW-1:0] win_base_q,
  input logic [OW-1:0] size_q
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !busy && !req_valid && !done && !wb_valid); // R1
  AST_IDX_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    idx_rd_en && src_q |-> (idx_rd_addr - win_base_q) < AW'(size_q)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R7
  AST_NO_READ_DURING_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !idx_rd_en); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !idx_rd_en && !done); // R2
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done && src_q); // R9

endmodule

bind cwin_gather_agen cwin_gather_agen_chk #(.AW(AW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .idx_rd_en(idx_rd_en), .idx_rd_addr(idx_rd_addr),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .done(done),
  .wb_valid(wb_valid), .src_q(src_q), .win_base_q(win_base_q), .size_q(size_q)
);

// File: tb/cwin_gather_agen_test.sv
`timescale 1ns/1ps
module cwin_gather_agen_test;
  localparam int AW = 32, IW = 16, CW = 16, OW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, src_sel = 1'b0;
  logic [CW-1:0] elem_count = '0;
  logic [AW-1:0] scalar_base = '0, table_base = '0, row_stride = '0, win_base = '0;
  logic [OW-1:0] win_size = '0, win_offset = '0;
  logic busy, idx_rd_en, req_valid, done, wb_valid;
  logic req_ready = 1'b1;
  logic [AW-1:0] idx_rd_addr, req_addr;
  logic [IW-1:0] idx_rd_data = '0;
  logic [OW-1:0] wb_offset;

  int n_cmp = 0, n_bad = 0;
  logic [AW-1:0] exp_q[$];
  logic bp_on = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #2 clk = ~clk;

  cwin_gather_agen #(.AW(AW), .IW(IW), .CW(CW), .OW(OW)) uut (.*);

  function automatic logic [IW-1:0] fmem(logic [AW-1:0] a);
    return IW'(a * 13 + 5);
  endfunction

  always @(posedge clk) begin
    if (idx_rd_en) idx_rd_data <= fmem(idx_rd_addr);
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    req_ready <= bp_on ? lfsr[0] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every accepted request is compared with the next expected row address (R7)
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R2/R7 unexpected request", req_addr, '0);
      else begin
        logic [AW-1:0] e;
        e = exp_q.pop_front();
        chk(req_addr == e, "R3/R4/R6 row address", req_addr, e);
      end
    end
  end

  task automatic push_stream(input bit src, input logic [AW-1:0] sb, input logic [AW-1:0] wb,
                             input int ws, input int wo, input logic [AW-1:0] tb,
                             input logic [AW-1:0] st, input int cnt, output int fin_off);
    int es, off;
    logic [AW-1:0] ia;
    es = (ws == 0) ? 1 : ws;
    off = wo % es;
    for (int k = 0; k < cnt; k++) begin
      ia = src ? wb + AW'(off) : sb + AW'(k);
      exp_q.push_back(tb + AW'(fmem(ia)) * st);
      off = (off + 1 == es) ? 0 : off + 1;
    end
    fin_off = off;
  endtask

  task automatic issue(input bit src, input logic [AW-1:0] sb, input logic [AW-1:0] wb,
                       input int ws, input int wo, input logic [AW-1:0] tb,
                       input logic [AW-1:0] st, input int cnt);
    @(negedge clk);
    src_sel = src; scalar_base = sb; win_base = wb; win_size = OW'(ws); win_offset = OW'(wo);
    table_base = tb; row_stride = st; elem_count = CW'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input bit src, input int fin_off);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done, "R8 done seen", AW'(done), 1);
    chk(exp_q.size() == 0, "R7 all requests before done", AW'(exp_q.size()), 0);
    chk(wb_valid == src, "R9 wb_valid with done", AW'(wb_valid), AW'(src));
    if (src) chk(wb_offset == OW'(fin_off), "R9 final offset", AW'(wb_offset), AW'(fin_off));
    @(negedge clk);
    chk(!done && !busy, "R8 done single pulse", AW'(done), 0);
  endtask

  task automatic run(input bit src, input logic [AW-1:0] sb, input logic [AW-1:0] wb,
                     input int ws, input int wo, input logic [AW-1:0] tb,
                     input logic [AW-1:0] st, input int cnt);
    int fo;
    push_stream(src, sb, wb, ws, wo, tb, st, cnt, fo);
    issue(src, sb, wb, ws, wo, tb, st, cnt);
    wait_done(src, fo);
  endtask

  initial begin
    int fo;
    repeat (3) @(negedge clk);
    chk(!busy && !req_valid && !idx_rd_en && !done && !wb_valid, "R1 reset state", AW'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !req_valid && !done, "R1 after reset", AW'(busy), 0);

    run(1'b0, 32'h200, 0, 0, 0, 32'h1000, 32'h40, 5);          // R3 scalar, R6
    bp_on = 1'b1;
    run(1'b1, 0, 32'h100, 4, 1, 32'h8000, 32'h20, 10);         // R4 wrap, R7 backpressure
    run(1'b1, 0, 32'h300, 4, 11, 32'h4000, 32'h8, 6);          // R5 oversized offset
    run(1'b1, 0, 32'h50, 0, 7, 32'h0, 32'h10, 3);              // R10 zero size
    run(1'b0, 32'h20, 0, 0, 0, 32'hFFFF0000, 32'h10000, 4);    // R6 truncation
    bp_on = 1'b0;

    // R8: count 0 scalar, done the cycle after start is sampled
    issue(1'b0, 0, 0, 0, 0, 0, 0, 0);
    chk(done && !wb_valid, "R8 zero-count done timing", AW'(done), 1);
    @(negedge clk);
    chk(!done && !busy, "R8 zero-count single pulse", AW'(done), 0);

    // R9: count 0 window returns reduced offset
    run(1'b1, 0, 32'h10, 4, 9, 0, 1, 0);

    // R2: start while busy is ignored
    bp_on = 1'b1;
    push_stream(1'b1, 0, 32'h700, 3, 2, 32'h9000, 32'h4, 8, fo);
    issue(1'b1, 0, 32'h700, 3, 2, 32'h9000, 32'h4, 8);
    repeat (4) @(negedge clk);
    chk(busy, "R2 busy during stream", AW'(busy), 1);
    issue(1'b0, 32'h5000, 0, 0, 0, 32'h12345, 32'h3, 6);
    wait_done(1'b1, fo);
    repeat (30) @(negedge clk);
    chk(!busy && !req_valid, "R2 no second stream", AW'(busy), 0);
    bp_on = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule